// File: doc/BRIEF.md
# Serial Command Latch Port

This block is a serial slave port with an active-low select. Each frame carries one word in each direction, least significant bit first. A command word arrives on the data input, and a response word leaves on the data output. The low `CMD_W` bits of a command word are an address, and the bits above them are data. When the select is released, the block counts the clock pulses of the frame. If the count is allowed, it writes the data into the addressed holding latch. The latch contents are presented in parallel to the measurement logic around the block.

The response of each frame is chosen when the select falls. The choice comes from the address still held in the shift register, which is the address of the previous frame. One address is reserved for reading the status word. A failure flag is the OR of the status bits, with one bit position left out.

The select, clock and data inputs are asynchronous. They pass through two-flop synchronizers on a system clock that runs at least eight times faster than the serial clock. Edges are then detected on that clock.

Top module: `spi_cmd_latch`

## Requirements
- R1: While `ncs_i` is high, `sdo_oe_o` is low and serial clock or data activity leaves the held word unchanged. The response of the next frame shows this.
- R2: Data on `sdi_i` is captured on serial clock falling edges, least significant bit first. The k-th falling edge of a frame writes bit k-1 of the held word. Bits [3:0] are the address and bits [15:4] are data.
- R3: After a 16-pulse frame with address c in 0..14, `latch_o[c*12 +: 12]` holds bits [15:4] of that word. No latch changes while `ncs_i` is low.
- R4: An 8-pulse frame replaces only held bits [7:0]. If it executes, it writes held bits [15:4], whose top 8 bits are left over from earlier frames.
- R5: A frame whose falling-edge count is not 0, 8 or 16 writes no latch.
- R6: A frame with no clock pulses executes the held word again.
- R7: When `ncs_i` falls, the response is chosen from held address c. For c < 15 it is {latch c, c}. For c = 15 it is {`stat_i`, 4'hF}.
- R8: While selected, `sdo_oe_o` is high, and after the (i+1)-th serial clock rising edge `sdo_o` carries response bit i.
- R9: Address 15 is the status read and never writes a latch.
- R10: `fsi_o` is the OR of all `stat_i` bits except bit 6.
- R11: After reset, every latch and the held word are zero and `sdo_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ncs_i | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock, idle low |
| sdi_i | input | 1 | Serial command data |
| sdo_o | output | 1 | Serial response data |
| sdo_oe_o | output | 1 | Output enable for `sdo_o`; low means high impedance |
| stat_i | input | 12 | Status word from the measurement logic |
| fsi_o | output | 1 | Failure flag |
| latch_o | output | 180 | Fifteen 12-bit latches; latch c at bits [c*12 +: 12] |

## Verification
The bench writes all fifteen latches and reads each one back through the following frame's response. A design that picks the response from the current frame's address, or that sends the most significant bit first, returns the wrong word.

Frames of 1, 4, 7, 9, 12, 15, 17 and 20 pulses test the length filter. A design with a loose filter lets one of them corrupt a latch.

An 8-pulse frame shows whether the upper held bits survive. A zero-pulse frame that follows an aborted 12-pulse frame must commit the partly rewritten word.

Serial clock activity while deselected, one-hot status patterns including bit 6, and the reserved status address each target a different way to get the decode wrong.

// File: rtl/spi_cmd_latch.sv
module spi_cmd_latch #(
  parameter int WORD_W   = 16,
  parameter int CMD_W    = 4,
  parameter int SKIP_BIT = 6
) (
  input  logic                                                clk,
  input  logic                                                rst_n,
  input  logic                                                ncs_i,
  input  logic                                                sclk_i,
  input  logic                                                sdi_i,
  output logic                                                sdo_o,
  output logic                                                sdo_oe_o,
  input  logic [WORD_W-CMD_W-1:0]                             stat_i,
  output logic                                                fsi_o,
  output logic [((1<<CMD_W)-1)*(WORD_W-CMD_W)-1:0]            latch_o
);
  localparam int DATA_W = WORD_W - CMD_W;
  localparam int NLATCH = (1 << CMD_W) - 1;
  localparam int HALF   = WORD_W / 2;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int CNT_W  = IDX_W + 2;
  localparam logic [CMD_W-1:0]  STAT_CMD = CMD_W'(NLATCH);
  localparam logic [DATA_W-1:0] FMASK    = ~(DATA_W'(1) << SKIP_BIT);

  logic [2:0] ncs_p, sclk_p, sdi_p;
  logic [CNT_W-1:0] cnt_q;
  logic [WORD_W-1:0] sr_q, tx_q, resp_sel;
  logic [NLATCH-1:0][DATA_W-1:0] lat_q;
  logic sdo_q;

  wire sel      = !ncs_p[1];
  wire ncs_fall = ncs_p[2] & !ncs_p[1];
  wire ncs_rise = !ncs_p[2] & ncs_p[1];
  wire sck_rise = sel & sclk_p[1] & !sclk_p[2];
  wire sck_fall = sel & !sclk_p[1] & sclk_p[2];
  wire [CMD_W-1:0]  cmd  = sr_q[CMD_W-1:0];
  wire [DATA_W-1:0] data = sr_q[WORD_W-1:CMD_W];
  wire cnt_ok = (cnt_q == '0) || (cnt_q == CNT_W'(HALF)) || (cnt_q == CNT_W'(WORD_W));

  assign resp_sel = (cmd == STAT_CMD) ? {stat_i, cmd} : {lat_q[cmd], cmd};
  assign sdo_oe_o = sel;
  assign sdo_o    = sel & sdo_q;
  assign fsi_o    = |(stat_i & FMASK);
  assign latch_o  = lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ncs_p  <= 3'b111;
      sclk_p <= '0;
      sdi_p  <= '0;
    end else begin
      ncs_p  <= {ncs_p[1:0], ncs_i};
      sclk_p <= {sclk_p[1:0], sclk_i};
      sdi_p  <= {sdi_p[1:0], sdi_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (ncs_fall) begin
      cnt_q <= '0;
    end else if (sck_fall) begin
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      if (cnt_q < CNT_W'(WORD_W)) sr_q[cnt_q[IDX_W-1:0]] <= sdi_p[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      sdo_q <= 1'b0;
    end else if (ncs_fall) begin
      tx_q  <= resp_sel;
      sdo_q <= 1'b0;
    end else if (sck_rise) begin
      sdo_q <= tx_q[0];
      tx_q  <= tx_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else if (ncs_rise && cnt_ok && cmd != STAT_CMD) lat_q[cmd] <= data;
  end

  // R1
  desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(sr_q));
  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> $stable(lat_q));
  // R5
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ncs_rise && !cnt_ok) |=> $stable(lat_q));
  // R9
  stat_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ncs_rise && cmd == STAT_CMD) |=> $stable(lat_q));
  // R8
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(tx_q));
endmodule

// File: tb/spi_cmd_latch_tb.sv
module spi_cmd_latch_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ncs = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, fsi;
  logic [11:0] stat = '0;
  logic [179:0] latch;
  int checks = 0, fails = 0;

  logic [15:0] mdl_sr = '0;
  logic [14:0][11:0] mdl_lat = '0;

  always #2.5 clk = ~clk;

  spi_cmd_latch u_dut (
    .clk(clk), .rst_n(rst_n), .ncs_i(ncs), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .stat_i(stat), .fsi_o(fsi), .latch_o(latch)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] w, input int n, input string req);
    logic [15:0] exp_r, rd, msk;
    logic [3:0] c;
    bit oe_ok;
    c = mdl_sr[3:0];
    exp_r = (c == 4'hF) ? {stat, 4'hF} : {mdl_lat[c], c};
    rd = '0; msk = '0; oe_ok = 1'b1;
    ncs = 1'b0;
    wait_n(6);
    for (int i = 0; i < n; i++) begin
      sdi = (i < 16) ? w[i[3:0]] : 1'b0;
      wait_n(4);
      sclk = 1'b1;
      wait_n(6);
      if (!sdo_oe) oe_ok = 1'b0;
      if (i < 16) begin rd[i[3:0]] = sdo; msk[i[3:0]] = 1'b1; end
      sclk = 1'b0;
      wait_n(6);
      if (i < 16) mdl_sr[i[3:0]] = w[i[3:0]];
    end
    ncs = 1'b1;
    wait_n(8);
    if (n > 0) begin
      // R7 R8
      chk(((rd ^ exp_r) & msk) == 0 && oe_ok, {"R7/R8 response ", req}, 192'(rd & msk), 192'(exp_r & msk));
    end
    if ((n == 0 || n == 8 || n == 16) && mdl_sr[3:0] != 4'hF)
      mdl_lat[mdl_sr[3:0]] = mdl_sr[15:4];
    chk(latch == mdl_lat, req, 192'(latch), 192'(mdl_lat));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    // R11 reset state
    chk(latch == '0, "R11 latches", 192'(latch), 192'(0));
    chk(sdo_oe == 1'b0, "R11 oe", 192'(sdo_oe), 192'(0));
    chk(fsi == 1'b0, "R10 idle fsi", 192'(fsi), 192'(0));

    // R2 R3 R7 full sweep of latch addresses
    for (int c = 0; c < 15; c++)
      frame({12'((c * 293) ^ 12'hA5C), 4'(c)}, 16, "R3 write sweep");
    stat = 12'h5A3;
    // R9 status address writes nothing
    frame({12'hFFF, 4'hF}, 16, "R9 status write");
    frame({12'h0F0, 4'h1}, 16, "R7 status read");

    // R10 one-hot status sweep
    for (int b = 0; b < 12; b++) begin
      stat = 12'(1 << b);
      wait_n(2);
      chk(fsi == (b != 6), "R10 onehot", 192'(fsi), 192'(b != 6));
    end
    stat = 12'hFFF; wait_n(2);
    chk(fsi == 1'b1, "R10 all", 192'(fsi), 192'(1));

    // R4 half frames
    frame(16'h0035, 8, "R4 half a");
    frame(16'hFF92, 8, "R4 half b");
    frame(16'h1234, 16, "R4 reread");

    // R5 bad lengths
    frame(16'hBEE7, 1, "R5 len1");
    frame(16'hC0D2, 4, "R5 len4");
    frame(16'h7A16, 7, "R5 len7");
    frame(16'h93C8, 9, "R5 len9");
    frame(16'h4444, 12, "R5 len12");
    frame(16'hE3B1, 15, "R5 len15");
    frame(16'h6DD0, 17, "R5 len17");
    frame(16'h5A5B, 20, "R5 len20");

    // R6 zero-pulse re-execution after aborted frame
    frame(16'h3AB3, 16, "R6 setup");
    frame(16'h9C47, 12, "R6 abort");
    frame(16'h0000, 0, "R6 zero pulse");
    frame(16'h0007, 16, "R6 readback");

    // R1 activity while deselected
    for (int k = 0; k < 20; k++) begin
      sdi = k[0] ^ k[2];
      wait_n(3); sclk = 1'b1; wait_n(3);
      chk(sdo_oe == 1'b0, "R1 oe low", 192'(sdo_oe), 192'(0));
      sclk = 1'b0;
    end
    frame(16'h8882, 16, "R1 held word intact");
    frame(16'h0002, 16, "R1 final");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule